// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block sits at the front of a synchronous burst SRAM. It captures the external word address on a qualified address strobe and then produces the two low-order address bits for each beat of a four-beat burst. The upper address bits stay fixed for the whole burst. The low bits either count upward and wrap within the aligned four-word block, or are formed by XOR with the beat number, as chosen by a static strap.

There are two active-low strobes, one from a processor and one from a controller. The processor strobe has priority, but it only counts while the first chip enable is active. Chip enables are looked at only on cycles that load a new address. Those cycles decide whether the device is selected. While the device is deselected, advance requests are ignored.

All outputs are registered, or are derived only from registers and the static strap.

Top module: `burst_addr_seq`

## Requirements
- R1: During and directly after reset, `cur_addr` is 0, `selected` is 0 and `load_pulse` is 0.
- R2: On a rising edge where `strb_proc_n` is 0 and `en1_n` is 0, the whole `addr_in` is captured. From the next cycle `cur_addr` equals that address.
- R3: When both strobes are 0 and `en1_n` is 0, only the processor strobe is acted on. Exactly one load of `addr_in` takes place.
- R4: When `en1_n` is 1, `strb_proc_n` is ignored. If `strb_ctrl_n` is also 1, no load occurs, `load_pulse` stays 0 and the upper address bits are kept.
- R5: When `strb_ctrl_n` is 0 and the processor strobe is not acted on, `addr_in` is loaded whatever the level of `en1_n`.
- R6: On a loading edge, `selected` becomes 1 only if `en1_n`=0, `en2`=1 and `en3_n`=0. On non-loading edges the enables are ignored and `selected` keeps its value.
- R7: With `order_ilv`=0, each accepted advance sets the low two bits of `cur_addr` to the previous low bits plus one, modulo 4. The upper bits stay unchanged.
- R8: With `order_ilv`=1, the low two bits after k accepted advances (k = 0..3, modulo 4) equal the loaded start bits XOR k.
- R9: With `adv_n`=1 and no load, `cur_addr` and `selected` hold their values.
- R10: While `selected` is 0, `adv_n`=0 has no effect on `cur_addr` until the next load.
- R11: `load_pulse` is 1 in exactly the cycle after a loading edge, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External word address |
| strb_proc_n | input | 1 | Processor address strobe, active low |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| en2 | input | 1 | Chip enable 2, active high |
| en3_n | input | 1 | Chip enable 3, active low |
| order_ilv | input | 1 | Static burst order: 0 linear, 1 XOR-interleaved |
| cur_addr | output | ADDR_W | Current internal word address |
| selected | output | 1 | Device selected by the last load |
| load_pulse | output | 1 | A new address was loaded on the previous edge |

## Verification
Every result of this block appears one clock after the edge that samples its stimulus. This covers the captured address, the stepped low bits, the selected flag and the load pulse. The driver applies inputs on the falling edge and records the expected outputs right after the following rising edge. The monitor compares them a quarter period later, so each comparison sees exactly one edge's worth of register updates. The strap changes only on a falling edge, and it is part of the expectation recorded at the next rising edge.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PROC = 2'd1,
    SRC_CTRL = 2'd2
  } load_src_e;

  // all three enables active at their own polarity
  function automatic logic enables_ok(input logic e1_n, input logic e2, input logic e3_n);
    return (!e1_n) && e2 && (!e3_n);
  endfunction

endpackage

// File: rtl/bas_strobe_arb.sv
module bas_strobe_arb
  import burst_seq_pkg::*;
(
  input  logic      strb_proc_n,
  input  logic      strb_ctrl_n,
  input  logic      en1_n,
  output load_src_e src,
  output logic      load
);
  logic proc_take;
  logic ctrl_take;

  always_comb begin
    proc_take = !strb_proc_n && !en1_n;
    ctrl_take = !strb_ctrl_n && !proc_take;
    if (proc_take)      src = SRC_PROC;
    else if (ctrl_take) src = SRC_CTRL;
    else                src = SRC_NONE;
    load = proc_take || ctrl_take;
  end
endmodule

// File: rtl/bas_beat_counter.sv
module bas_beat_counter #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beats
);
  always_ff @(posedge clk) begin
    if (!rst_n)    beats <= '0;
    else if (load) beats <= '0;
    else if (step) beats <= beats + 1'b1;
  end
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beats,
  input  logic              ilv,
  output logic [BEAT_W-1:0] low
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  assign lin_low = start + beats;

  genvar gi;
  generate
    for (gi = 0; gi < BEAT_W; gi++) begin : g_xor
      assign ilv_low[gi] = start[gi] ^ beats[gi];
    end
  endgenerate

  assign low = ilv ? ilv_low : lin_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strb_proc_n,
  input  logic              strb_ctrl_n,
  input  logic              adv_n,
  input  logic              en1_n,
  input  logic              en2,
  input  logic              en3_n,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              selected,
  output logic              load_pulse
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  load_src_e         src;
  logic              load_evt;
  logic              step_evt;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beats;
  logic [BEAT_W-1:0] low_bits;

  bas_strobe_arb u_arb (
    .strb_proc_n (strb_proc_n),
    .strb_ctrl_n (strb_ctrl_n),
    .en1_n       (en1_n),
    .src         (src),
    .load        (load_evt)
  );

  assign step_evt = !load_evt && !adv_n && selected;

  bas_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_evt),
    .step  (step_evt),
    .beats (beats)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      selected   <= 1'b0;
      load_pulse <= 1'b0;
    end else begin
      load_pulse <= load_evt;
      if (src != SRC_NONE) begin
        base_q   <= addr_in;
        selected <= enables_ok(en1_n, en2, en3_n);
      end
    end
  end

  bas_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start (base_q[BEAT_W-1:0]),
    .beats (beats),
    .ilv   (order_ilv),
    .low   (low_bits)
  );

  assign cur_addr = {base_q[ADDR_W-1 -: HI_W], low_bits};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              strb_ctrl_n,
  input logic              adv_n,
  input logic              en1_n,
  input logic              order_ilv,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              selected,
  input logic              load_pulse,
  input logic              load_evt
);
  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (cur_addr == $past(addr_in)) && load_pulse);

  assert_proc_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en1_n && strb_ctrl_n) |=> !load_pulse);

  assert_ctrl_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_ctrl_n |=> load_pulse && (cur_addr == $past(addr_in)));

  assert_sel_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(selected));

  assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && adv_n) |=> (!$stable(order_ilv) || $stable(cur_addr)));

  assert_desel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!selected && !load_evt) |=> !selected && (!$stable(order_ilv) || $stable(cur_addr)));

  assert_no_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> !load_pulse);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_in     (addr_in),
  .strb_ctrl_n (strb_ctrl_n),
  .adv_n       (adv_n),
  .en1_n       (en1_n),
  .order_ilv   (order_ilv),
  .cur_addr    (cur_addr),
  .selected    (selected),
  .load_pulse  (load_pulse),
  .load_evt    (load_evt)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic strb_proc_n = 1'b1, strb_ctrl_n = 1'b1, adv_n = 1'b1;
  logic en1_n = 1'b1, en2 = 1'b0, en3_n = 1'b1, order_ilv = 1'b0;
  logic [ADDR_W-1:0] cur_addr;
  logic selected, load_pulse;

  always #(PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n),
    .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .order_ilv(order_ilv),
    .cur_addr(cur_addr), .selected(selected), .load_pulse(load_pulse)
  );

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic              sel;
    logic              pulse;
    string             tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  // independent model state
  logic [ADDR_W-1:0] m_base = '0;
  int                m_k = 0;
  logic              m_sel = 1'b0;

  function automatic logic [ADDR_W-1:0] model_addr();
    logic [1:0] s;
    logic [1:0] kk;
    logic [1:0] lo;
    s  = m_base[1:0];
    kk = 2'(m_k % 4);
    if (order_ilv) lo = {s[1] ^ kk[1], s[0] ^ kk[0]};
    else           lo = 2'((int'(s) + m_k) % 4);
    return {m_base[ADDR_W-1:2], lo};
  endfunction

  task automatic step(input logic pn, input logic cn, input logic an,
                      input logic e1, input logic e2v, input logic e3,
                      input logic [ADDR_W-1:0] a, input string tag);
    bit proc, ctrl, ld;
    exp_t e;
    strb_proc_n = pn; strb_ctrl_n = cn; adv_n = an;
    en1_n = e1; en2 = e2v; en3_n = e3; addr_in = a;
    proc = !pn && !e1;
    ctrl = !cn && !proc;
    ld   = proc || ctrl;
    if (ld) begin
      m_base = a; m_k = 0; m_sel = !e1 && e2v && !e3;
    end else if (!an && m_sel) begin
      m_k = m_k + 1;
    end
    @(posedge clk);
    e.addr = model_addr(); e.sel = m_sel; e.pulse = ld; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #(PERIOD/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (cur_addr !== e.addr || selected !== e.sel || load_pulse !== e.pulse) begin
        bad++;
        $display("FAIL %s: got addr=%h sel=%b pulse=%b exp addr=%h sel=%b pulse=%b",
                 e.tag, cur_addr, selected, load_pulse, e.addr, e.sel, e.pulse);
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (cur_addr !== '0 || selected !== 1'b0 || load_pulse !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: got addr=%h sel=%b pulse=%b exp 0 0 0", cur_addr, selected, load_pulse);
    end
    rst_n = 1'b1;
    order_ilv = 1'b0;
    // R2 R11: processor load, then linear wrap R7
    step(0, 1, 1, 0, 1, 0, 18'h2A5F2, "R2 proc load");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 1, 0, 18'h0, "R7 linear step");
    step(1, 1, 1, 0, 1, 0, 18'h3FFFF, "R9 hold");
    step(1, 1, 1, 1, 0, 1, 18'h11111, "R9 hold enables ignored");
    // R3 both strobes
    step(0, 0, 1, 0, 1, 0, 18'h01233, "R3 both strobes");
    step(1, 1, 0, 0, 1, 0, 18'h0, "R7 linear from 3 wraps");
    // R4 proc ignored with en1 high
    step(0, 1, 1, 1, 1, 0, 18'h3C000, "R4 proc ignored");
    step(0, 1, 0, 1, 1, 0, 18'h3C001, "R4 proc ignored advance");
    // R5 controller load with en1 high -> deselected R6
    step(1, 0, 1, 1, 1, 0, 18'h15550, "R5 ctrl load en1 high");
    step(1, 1, 0, 0, 1, 0, 18'h0, "R10 advance ignored");
    step(1, 1, 0, 0, 1, 0, 18'h0, "R10 advance ignored again");
    step(0, 1, 0, 1, 1, 0, 18'h0, "R10 proc blocked stays deselected");
    step(1, 0, 1, 0, 0, 0, 18'h0ABC1, "R6 ctrl load en2 low");
    step(1, 0, 1, 0, 1, 0, 18'h0ABC2, "R6 ctrl load all active");
    step(1, 1, 0, 1, 0, 1, 18'h0, "R6 enables ignored while advancing");
    step(0, 1, 1, 0, 1, 1, 18'h22221, "R6 proc load en3 high");
    step(1, 1, 0, 0, 1, 0, 18'h0, "R10 advance while deselected");
    // interleaved R8
    order_ilv = 1'b1;
    step(0, 1, 1, 0, 1, 0, 18'h31231, "R8 ilv load start 1");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 1, 0, 18'h0, "R8 ilv step");
    step(1, 0, 1, 0, 1, 0, 18'h20002, "R8 ilv load start 2");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 1, 0, 18'h0, "R8 ilv step");
    step(1, 1, 1, 0, 1, 0, 18'h0, "R9 ilv hold");
    step(1, 1, 1, 0, 1, 0, 18'h0, "R11 no pulse");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule